// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer

This block caches recent virtual-page to physical-page translations in front of a page-table walker. Any entry can hold any page. A lookup presents a 20-bit virtual page number and a 12-bit page offset. In the same cycle, with no page-table access, the block answers hit or miss and returns the physical page number, the permission bits and the joined physical address. When a lookup misses, the walker request goes high. The walker later returns a translation on the fill port, and the requester then retries.

The buffer never writes anything back to memory. A mapping can leave it in only three ways:
- a flush pulse, issued whenever the page-table base register is written, clears every entry;
- an invalidate pulse, issued after software edits a page-table entry, clears the one entry whose tag matches;
- an eviction during a fill.

A fill picks its slot in this order: the entry that already holds the same page, then the lowest-numbered empty entry, then the least recently used entry.

The fill port is a stream with no back-pressure. A fill is accepted in every cycle its valid is high, so the walker never waits. The lookup port is combinational and has no handshake. Flush and invalidate are plain pulses.

Top module: `tlb_fa`

## Requirements
- R1: After reset every entry is empty, so any lookup misses.
- R2: A lookup with `lk_valid` high hits in the same cycle when a valid entry's tag equals `lk_vpn`. It then outputs that entry's page number on `lk_ppn`, its permissions on `lk_perm` (bit 3 dirty, bit 2 execute, bit 1 write, bit 0 read), and `lk_paddr = {lk_ppn, lk_offset}`.
- R3: `walk_req` is high in exactly the cycles where `lk_valid` is high and `lk_hit` is low.
- R4: A write lookup (`lk_write` high) that matches an entry whose dirty bit (perm bit 3) is 0 reports a miss and raises `walk_req`. A read lookup of the same entry hits.
- R5: A fill is accepted in every cycle `fill_valid` is high and is visible to lookups from the next cycle. A fill whose page is already present overwrites that entry, so no two valid entries ever share a tag.
- R6: A fill of a new page uses the lowest-numbered empty entry if one exists. A full set of 16 distinct fills after a flush therefore leaves all 16 pages resident.
- R7: When no entry is empty, a fill of a new page replaces the entry least recently hit or filled.
- R8: A `base_wr` pulse empties the whole buffer from the next cycle.
- R9: An `inval_valid` pulse removes only the entry tagged `inval_vpn`; every other entry keeps hitting.
- R10: When a fill coincides with a flush or an invalidate, the fill is applied first. A flush therefore discards the new entry, and an invalidate of the same page discards it too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_write | input | 1 | Lookup is for a store |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_offset | input | 12 | Byte offset within the page |
| lk_hit | output | 1 | Lookup hit (combinational) |
| lk_ppn | output | 20 | Physical page number of the hit entry |
| lk_perm | output | 4 | {dirty, execute, write, read} of the hit entry |
| lk_paddr | output | 32 | Physical address {ppn, offset} |
| walk_req | output | 1 | Miss; walker must fetch the translation |
| fill_valid | input | 1 | Fill beat present, always accepted |
| fill_vpn | input | 20 | Virtual page being installed |
| fill_ppn | input | 20 | Physical page being installed |
| fill_perm | input | 4 | {dirty, execute, write, read} being installed |
| base_wr | input | 1 | Page-table base written: flush all |
| inval_valid | input | 1 | Invalidate one page |
| inval_vpn | input | 20 | Page to invalidate |

## Verification
The assertions check the following on every cycle:
- tags stay unique across valid entries;
- a write hit always carries a set dirty bit;
- a page that was just filled is seen on the next cycle, and one that was just invalidated or flushed is not;
- the age counters keep exactly one oldest and one newest entry.

Some behaviour needs a history of operations, so only the bench scenarios can show it:
- the replacement order, including which of the 16 entries leaves when a 17th page arrives after an earlier page was touched;
- the choice of empty slot over eviction;
- how same-cycle fill and flush or invalidate combine.

The random phase compares every lookup against a reference model under mixed fills, flushes and invalidates, using a page pool larger than the buffer.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Permission bits as carried on the ports: {dirty, exec, wr, rd}.
  typedef struct packed {
    logic dirty;
    logic exec;
    logic wr;
    logic rd;
  } perm_t;

  localparam int PERM_W = $bits(perm_t);
endpackage

// File: rtl/tlb_cam_match.sv
// Parallel tag comparison against every entry.
module tlb_cam_match #(
  parameter int N     = 16,
  parameter int TAG_W = 20
) (
  input  logic [N-1:0]            valid,
  input  logic [N-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]        key,
  output logic [N-1:0]            hits
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hits[i] = valid[i] && (tags[i] == key);
  end
endmodule

// File: rtl/tlb_lru_ages.sv
// Per-entry age counters; ages always form a permutation of 0..N-1.
module tlb_lru_ages #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] lru_idx
);
  logic [N-1:0][IDX_W-1:0] age_q;
  logic [N-1:0]            is_lru;
  logic [N-1:0]            is_mru;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (touch_idx == IDX_W'(i))
          age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx])
          age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    lru_idx = '0;
    for (int i = 0; i < N; i++) begin
      is_lru[i] = (age_q[i] == IDX_W'(N - 1));
      is_mru[i] = (age_q[i] == '0);
      if (is_lru[i]) lru_idx = IDX_W'(i);
    end
  end

  // R7: the age order keeps one unique oldest and one unique newest entry
  a_r7_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(is_lru));
  a_r7_single_newest: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(is_mru));
endmodule

// File: rtl/tlb_fill_pick.sv
// Fill slot choice: same page, else lowest empty slot, else LRU.
module tlb_fill_pick #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     valid,
  input  logic [N-1:0]     same_tag,
  input  logic [IDX_W-1:0] lru_idx,
  output logic [IDX_W-1:0] tgt_idx
);
  always_comb begin
    tgt_idx = lru_idx;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) tgt_idx = IDX_W'(i);
    end
    for (int i = 0; i < N; i++) begin
      if (same_tag[i]) tgt_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic              lk_write,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [OFF_W-1:0]  lk_offset,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [PERM_W-1:0] lk_perm,
  output logic [PA_W-1:0]   lk_paddr,
  output logic              walk_req,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              base_wr,
  input  logic              inval_valid,
  input  logic [VPN_W-1:0]  inval_vpn
);
  logic [ENTRIES-1:0]             valid_q, valid_nx;
  logic [ENTRIES-1:0][VPN_W-1:0]  tag_q, tag_nx;
  logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
  perm_t [ENTRIES-1:0]            perm_q;
  logic [ENTRIES-1:0]             lk_hits, fill_hits;
  logic [IDX_W-1:0]               lk_idx, lru_idx, tgt_idx, touch_idx;
  logic                           raw_hit, touch;
  perm_t                          sel_perm;

  tlb_cam_match #(.N(ENTRIES), .TAG_W(VPN_W)) u_lk_match (
    .valid(valid_q), .tags(tag_q), .key(lk_vpn), .hits(lk_hits));

  tlb_cam_match #(.N(ENTRIES), .TAG_W(VPN_W)) u_fill_match (
    .valid(valid_q), .tags(tag_q), .key(fill_vpn), .hits(fill_hits));

  always_comb begin
    lk_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_hits[i]) lk_idx = IDX_W'(i);
    end
  end

  // Lookup result, same cycle.
  assign raw_hit  = |lk_hits;
  assign sel_perm = perm_q[lk_idx];
  assign lk_hit   = lk_valid && raw_hit && !(lk_write && !sel_perm.dirty);
  assign walk_req = lk_valid && !lk_hit;
  assign lk_ppn   = ppn_q[lk_idx];
  assign lk_perm  = sel_perm;
  assign lk_paddr = {ppn_q[lk_idx], lk_offset};

  tlb_fill_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .valid(valid_q), .same_tag(fill_hits), .lru_idx(lru_idx), .tgt_idx(tgt_idx));

  assign touch     = fill_valid || lk_hit;
  assign touch_idx = fill_valid ? tgt_idx : lk_idx;

  tlb_lru_ages #(.N(ENTRIES), .IDX_W(IDX_W)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch(touch), .touch_idx(touch_idx), .lru_idx(lru_idx));

  // Fill first, then invalidate and flush act on the post-fill contents.
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      tag_nx[i]   = tag_q[i];
      valid_nx[i] = valid_q[i];
      if (fill_valid && (tgt_idx == IDX_W'(i))) begin
        tag_nx[i]   = fill_vpn;
        valid_nx[i] = 1'b1;
      end
      if (inval_valid && (tag_nx[i] == inval_vpn)) valid_nx[i] = 1'b0;
      if (base_wr) valid_nx[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_nx;
  end

  always_ff @(posedge clk) begin
    tag_q <= tag_nx;
    if (fill_valid) begin
      ppn_q[tgt_idx]  <= fill_ppn;
      perm_q[tgt_idx] <= perm_t'(fill_perm);
    end
  end

  // R5: no two valid entries share a tag
  a_r5_unique_tags: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hits));
  // R5: a fill that no flush/invalidate cancels is seen on the next cycle
  a_r5_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !base_wr && !(inval_valid && inval_vpn == fill_vpn)) |=>
      (!(lk_valid && !lk_write && lk_vpn == $past(fill_vpn)) || lk_hit));
  // R4: a store only hits a page whose dirty bit is set
  a_r4_store_needs_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_write) |-> lk_perm[3]);
  // R8: nothing hits right after a flush
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |=> !lk_hit);
  // R9: the invalidated page misses on the next cycle
  a_r9_inval_removes: assert property (@(posedge clk) disable iff (!rst_n)
    inval_valid |=> !(lk_hit && lk_vpn == $past(inval_vpn)));
endmodule

// File: tb/test_tlb_fa.sv
module test_tlb_fa;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int N  = 16;
  localparam int VW = 20;
  localparam int PW = 20;
  localparam int OW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid, lk_write;
  logic [VW-1:0] lk_vpn;
  logic [OW-1:0] lk_offset;
  logic lk_hit, walk_req;
  logic [PW-1:0] lk_ppn;
  logic [3:0] lk_perm;
  logic [PW+OW-1:0] lk_paddr;
  logic fill_valid;
  logic [VW-1:0] fill_vpn;
  logic [PW-1:0] fill_ppn;
  logic [3:0] fill_perm;
  logic base_wr, inval_valid;
  logic [VW-1:0] inval_vpn;

  int checks = 0;
  int errors = 0;

  bit            m_valid[N];
  logic [VW-1:0] m_tag[N];
  logic [PW-1:0] m_ppn[N];
  logic [3:0]    m_perm[N];
  int            m_age[N];

  always #2 clk = ~clk;

  tlb_fa i_tlb_fa (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int m_find(logic [VW-1:0] v);
    for (int i = 0; i < N; i++) if (m_valid[i] && m_tag[i] == v) return i;
    return -1;
  endfunction

  task automatic idle();
    lk_valid = 0; lk_write = 0; lk_vpn = '0; lk_offset = '0;
    fill_valid = 0; fill_vpn = '0; fill_ppn = '0; fill_perm = '0;
    base_wr = 0; inval_valid = 0; inval_vpn = '0;
  endtask

  task automatic model_update(bit eh, int h);
    int t = -1;
    int tch = -1;
    if (fill_valid) begin
      t = m_find(fill_vpn);
      if (t < 0) for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) t = i;
      if (t < 0) for (int i = 0; i < N; i++) if (m_age[i] == N - 1) t = i;
      m_valid[t] = 1; m_tag[t] = fill_vpn; m_ppn[t] = fill_ppn; m_perm[t] = fill_perm;
      tch = t;
    end else if (eh) tch = h;
    if (tch >= 0) begin
      int a = m_age[tch];
      for (int i = 0; i < N; i++) begin
        if (i == tch) m_age[i] = 0;
        else if (m_age[i] < a) m_age[i]++;
      end
    end
    if (inval_valid) for (int i = 0; i < N; i++) if (m_tag[i] == inval_vpn) m_valid[i] = 0;
    if (base_wr) for (int i = 0; i < N; i++) m_valid[i] = 0;
  endtask

  // Called just after a falling edge with inputs already driven.
  task automatic step(string req);
    int h;
    bit eh;
    #1;
    h  = m_find(lk_vpn);
    eh = lk_valid && (h >= 0) && !(lk_write && !m_perm[h][3]);
    chk(req, lk_hit, eh);
    chk({req, "/R3"}, walk_req, lk_valid && !eh);
    if (eh) begin
      chk(req, lk_ppn, m_ppn[h]);
      chk(req, lk_perm, m_perm[h]);
      chk({req, "/R2"}, lk_paddr, {m_ppn[h], lk_offset});
    end
    @(posedge clk);
    model_update(eh, h);
    @(negedge clk);
  endtask

  task automatic look(logic [VW-1:0] v, bit wr);
    idle(); lk_valid = 1; lk_vpn = v; lk_write = wr; lk_offset = OW'($urandom);
  endtask

  task automatic fill(logic [VW-1:0] v, logic [PW-1:0] p, logic [3:0] pm);
    idle(); fill_valid = 1; fill_vpn = v; fill_ppn = p; fill_perm = pm;
  endtask

  task automatic expect_hit(string req, logic [VW-1:0] v, bit wr, bit e);
    look(v, wr);
    #1 chk(req, lk_hit, e);
    step(req);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    idle();
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_age[i] = i; m_tag[i] = '0; m_ppn[i] = '0; m_perm[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: empty after reset
    expect_hit("R1", 20'h00005, 0, 0);

    // R2: fill then same-cycle lookup hit with joined address
    fill(20'h12345, 20'h54321, 4'b1011); step("R2");
    expect_hit("R2", 20'h12345, 0, 1);
    expect_hit("R2", 20'h12345, 1, 1);

    // R3: unknown page raises the walker request
    expect_hit("R3", 20'h0BEEF, 0, 0);

    // R4: store to clean page misses, load hits; R5: refill with dirty overwrites
    fill(20'h00B0B, 20'h00AAA, 4'b0011); step("R4");
    expect_hit("R4", 20'h00B0B, 1, 0);
    expect_hit("R4", 20'h00B0B, 0, 1);
    fill(20'h00B0B, 20'h00CCC, 4'b1011); step("R5");
    expect_hit("R5", 20'h00B0B, 1, 1);
    look(20'h00B0B, 0); #1 chk("R5", lk_ppn, 20'h00CCC); step("R5");

    // R8 then R6: 16 distinct fills into an empty buffer all stay resident
    idle(); base_wr = 1; step("R8");
    expect_hit("R8", 20'h12345, 0, 0);
    for (int k = 0; k < N; k++) begin
      fill(20'h00100 + VW'(k), 20'h0F000 + PW'(k), 4'b1111); step("R6");
    end
    for (int k = 0; k < N; k++) expect_hit("R6", 20'h00100 + VW'(k), 0, 1);

    // R7: touch oldest page, new fill evicts the next-oldest
    expect_hit("R7", 20'h00100, 0, 1);
    fill(20'h00200, 20'h0E000, 4'b1111); step("R7");
    expect_hit("R7", 20'h00100, 0, 1);
    expect_hit("R7", 20'h00101, 0, 0);
    expect_hit("R7", 20'h00102, 0, 1);
    expect_hit("R7", 20'h00200, 0, 1);

    // R9: single-page invalidate
    idle(); inval_valid = 1; inval_vpn = 20'h00105; step("R9");
    expect_hit("R9", 20'h00105, 0, 0);
    expect_hit("R9", 20'h00106, 0, 1);

    // R8: flush
    idle(); base_wr = 1; step("R8");
    expect_hit("R8", 20'h00100, 0, 0);

    // R10: same-cycle fill with flush / invalidate
    fill(20'h00300, 20'h00111, 4'b1111); base_wr = 1; step("R10");
    expect_hit("R10", 20'h00300, 0, 0);
    fill(20'h00301, 20'h00222, 4'b1111); step("R10");
    fill(20'h00302, 20'h00333, 4'b1111); inval_valid = 1; inval_vpn = 20'h00302; step("R10");
    expect_hit("R10", 20'h00302, 0, 0);
    fill(20'h00303, 20'h00444, 4'b1111); inval_valid = 1; inval_vpn = 20'h00301; step("R10");
    expect_hit("R10", 20'h00303, 0, 1);
    expect_hit("R10", 20'h00301, 0, 0);

    // Random mix against the model (R7 replacement under pressure)
    for (int c = 0; c < 4000; c++) begin
      idle();
      lk_valid    = ($urandom % 4) != 0;
      lk_vpn      = 20'h80000 + VW'($urandom % 24);
      lk_write    = ($urandom % 3) == 0;
      lk_offset   = OW'($urandom);
      fill_valid  = ($urandom % 4) == 0;
      fill_vpn    = 20'h80000 + VW'($urandom % 24);
      fill_ppn    = PW'($urandom);
      fill_perm   = 4'($urandom);
      base_wr     = ($urandom % 100) == 0;
      inval_valid = ($urandom % 16) == 0;
      inval_vpn   = 20'h80000 + VW'($urandom % 24);
      step("R7");
    end

    idle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule